// File: doc/BRIEF.md
# Compact 16-bit Byte-Addressed Processor Core

A small multi-cycle processor that runs five instructions of a 16-bit byte-addressed load/store instruction set: register and immediate ADD, PC-relative address generation (LEA), word load (LDW), conditional branch (BR) and trap (TRAP). It has eight 16-bit general registers, a program counter and a three-flag condition code (negative, zero, positive). Instructions and data share one synchronous RAM built from two byte lanes inside the block. The RAM decodes only the low `MEM_AW` address bits, so higher addresses alias.

A host fills the RAM through a write port while the core is held in reset, then releases reset. The core then fetches from 0x3000. It stops for good once its program counter becomes 0x0000. It reports a retired-instruction count, the program counter, the condition code, a halted flag, and the value of one general register picked by a select input.

Top module: `m16_core`

## Requirements
- R1: While reset is asserted the PC reads 0x3000, the retired count is 0, halted is 0, every general register reads 0, and the condition code reads Z (cc_o = 3'b010, where bit 2 is N, bit 1 is Z and bit 0 is P).
- R2: ADD (opcode 0001, DR [11:9], SR1 [8:6]) writes SR1 plus a second operand. When bit 5 is 1 the operand is bits [4:0] sign-extended to 16 bits. When bit 5 is 0 it is register [2:0]. The result sets exactly one flag.
- R3: LEA (opcode 1110, DR [11:9], 9-bit offset [8:0]) writes PC+2 plus the sign-extended offset shifted left by one, and sets the flags from that value.
- R4: LDW (opcode 0110, DR [11:9], base [8:6], 6-bit offset [5:0]) loads the word at base plus the sign-extended offset shifted left by one. Address bit 0 is ignored. The flags are set from the loaded word.
- R5: BR (opcode 0000, mask [11:9] in N,Z,P order, 9-bit offset) goes to PC+2 plus the offset shifted left by one when any masked flag is set. Otherwise it falls through to PC+2. A mask of 000 never branches.
- R6: TRAP (opcode 1111, vector [7:0]) writes PC+2 to R7 and loads the PC from the word at the vector shifted left by one. It does not change the flags.
- R7: Once the PC becomes 0x0000 the core raises halted, stops fetching, and holds the PC and the retired count.
- R8: Each executed instruction adds one to the retired count. Opcodes outside the five above only advance the PC by 2.
- R9: Non-memory instructions take two cycles (fetch, execute). LDW and TRAP take three (fetch, execute, memory). The count never steps twice in a row.
- R10: The count-down program E005 6200 127F 0401 0FFD F025 000A at 0x3000, with word 0x004A equal to 0, halts after 32 instructions with R0 = 0x300C, R1 = 0, R7 = 0x300C, Z set and PC = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_we_i | input | 1 | RAM word write strobe from the host |
| load_addr_i | input | MEM_AW | Byte address of the host write (bit 0 ignored) |
| load_data_i | input | 16 | Word written by the host |
| dbg_sel_i | input | 3 | Selects the general register shown on dbg_data_o |
| dbg_data_o | output | 16 | Value of the selected general register |
| pc_o | output | 16 | Program counter |
| cc_o | output | 3 | Condition code {N,Z,P} |
| retired_o | output | CNT_W | Retired-instruction count |
| halted_o | output | 1 | Core has stopped at PC 0x0000 |

## Verification
The bench targets the following edge cases, each of which a flawed design would get wrong:
- Negative immediates and offsets: a design that zero-extends them instead of sign-extending yields 0x0018-style values, or branch targets and addresses that land forward.
- An odd base address: a core that does not drop bit 0 loads the wrong word.
- TRAP with a negative result in flight: a core that lets the link write update the flags ends with P instead of N.
- Branch masks: a core that treats 000 as "always" executes the wrong path.
- After halt: a core that keeps fetching lets the count or PC drift, and the count-down loop then finishes with a wrong count.

// File: rtl/m16_pkg.sv
package m16_pkg;
  localparam int unsigned XLEN = 16;

  localparam logic [3:0] OP_BR   = 4'b0000;
  localparam logic [3:0] OP_ADD  = 4'b0001;
  localparam logic [3:0] OP_LDW  = 4'b0110;
  localparam logic [3:0] OP_LEA  = 4'b1110;
  localparam logic [3:0] OP_TRAP = 4'b1111;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_MEM   = 2'd2,
    ST_HALT  = 2'd3
  } state_e;

  typedef struct packed {
    logic            rf_we;
    logic [2:0]      rf_addr;
    logic [XLEN-1:0] rf_data;
    logic            cc_we;
    logic            mem_rd;
    logic [XLEN-1:0] mem_addr;
    logic [XLEN-1:0] next_pc;
  } exec_res_t;

  function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] raw, input int unsigned width);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = (i < int'(width)) ? raw[i] : raw[width-1];
    return r;
  endfunction

  // {N,Z,P}
  function automatic logic [2:0] flags_of(input logic [XLEN-1:0] v);
    return {v[XLEN-1], (v == '0), (!v[XLEN-1] && (v != '0))};
  endfunction
endpackage

// File: rtl/m16_regfile.sv
module m16_regfile #(
  parameter int unsigned NREG = 8,
  parameter int unsigned W    = 16,
  parameter int unsigned NRD  = 3,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]  rdata_o
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rdata_o[p] = regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/m16_mem.sv
module m16_mem #(
  parameter int unsigned AW    = 12,
  localparam int unsigned WAW  = AW - 1,
  localparam int unsigned DEPTH = 1 << WAW
) (
  input  logic           clk_i,
  input  logic           rd_en_i,
  input  logic [WAW-1:0] rd_word_i,
  output logic [15:0]    rd_data_o,
  input  logic           wr_en_i,
  input  logic [WAW-1:0] wr_word_i,
  input  logic [15:0]    wr_data_i
);
  // lane 0 holds the low byte (lower byte address)
  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic [7:0] bank [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i) bank[wr_word_i] <= wr_data_i[8*b +: 8];
      if (rd_en_i) q <= bank[rd_word_i];
    end
    assign rd_data_o[8*b +: 8] = q;
  end
endmodule

// File: rtl/m16_exec.sv
module m16_exec
  import m16_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_inc_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [2:0]      cc_i,
  output exec_res_t       res_o
);
  logic [3:0]      op;
  logic [XLEN-1:0] off9_x2, off6_x2, imm5, opnd_b;
  logic            br_take;

  assign op      = instr_i[15:12];
  assign off9_x2 = sext(XLEN'(instr_i[8:0]), 9) << 1;
  assign off6_x2 = sext(XLEN'(instr_i[5:0]), 6) << 1;
  assign imm5    = sext(XLEN'(instr_i[4:0]), 5);
  assign opnd_b  = instr_i[5] ? imm5 : src_b_i;
  assign br_take = |(instr_i[11:9] & cc_i);

  always_comb begin
    res_o          = '0;
    res_o.rf_addr  = instr_i[11:9];
    res_o.next_pc  = pc_inc_i;
    unique case (op)
      OP_ADD: begin
        res_o.rf_we   = 1'b1;
        res_o.cc_we   = 1'b1;
        res_o.rf_data = src_a_i + opnd_b;
      end
      OP_LEA: begin
        res_o.rf_we   = 1'b1;
        res_o.cc_we   = 1'b1;
        res_o.rf_data = pc_inc_i + off9_x2;
      end
      OP_LDW: begin
        res_o.mem_rd   = 1'b1;
        res_o.mem_addr = src_a_i + off6_x2;
      end
      OP_BR: begin
        if (br_take) res_o.next_pc = pc_inc_i + off9_x2;
      end
      OP_TRAP: begin
        res_o.rf_we    = 1'b1;
        res_o.rf_addr  = 3'd7;
        res_o.rf_data  = pc_inc_i;
        res_o.mem_rd   = 1'b1;
        res_o.mem_addr = {7'b0, instr_i[7:0], 1'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/m16_core.sv
module m16_core
  import m16_pkg::*;
#(
  parameter int unsigned   MEM_AW   = 12,
  parameter int unsigned   CNT_W    = 32,
  parameter int unsigned   NREG     = 8,
  parameter logic [15:0]   RESET_PC = 16'h3000,
  localparam int unsigned  RAW      = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [15:0]       load_data_i,
  input  logic [2:0]        dbg_sel_i,
  output logic [15:0]       dbg_data_o,
  output logic [15:0]       pc_o,
  output logic [2:0]        cc_o,
  output logic [CNT_W-1:0]  retired_o,
  output logic              halted_o
);
  state_e            state_q, state_d;
  logic [XLEN-1:0]   pc_q, pc_d;
  logic [2:0]        cc_q, cc_d;
  logic [CNT_W-1:0]  retired_q, retired_d;
  logic [3:0]        ir_op_q, ir_op_d;
  logic [2:0]        ir_dr_q, ir_dr_d;

  logic              mem_rd;
  logic [XLEN-1:0]   mem_addr;
  logic [XLEN-1:0]   mem_rdata;

  logic                   rf_we;
  logic [RAW-1:0]         rf_waddr;
  logic [XLEN-1:0]        rf_wdata;
  logic [2:0][RAW-1:0]    rf_raddr;
  logic [2:0][XLEN-1:0]   rf_rdata;

  exec_res_t         res;
  logic [XLEN-1:0]   pc_inc;

  assign pc_inc = pc_q + XLEN'(2);

  m16_mem #(.AW(MEM_AW)) u_mem (
    .clk_i     (clk_i),
    .rd_en_i   (mem_rd),
    .rd_word_i (mem_addr[MEM_AW-1:1]),
    .rd_data_o (mem_rdata),
    .wr_en_i   (load_we_i),
    .wr_word_i (load_addr_i[MEM_AW-1:1]),
    .wr_data_i (load_data_i)
  );

  assign rf_raddr[0] = RAW'(mem_rdata[8:6]);
  assign rf_raddr[1] = RAW'(mem_rdata[2:0]);
  assign rf_raddr[2] = RAW'(dbg_sel_i);

  m16_regfile #(.NREG(NREG), .W(XLEN), .NRD(3)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  m16_exec u_exec (
    .instr_i  (mem_rdata),
    .pc_inc_i (pc_inc),
    .src_a_i  (rf_rdata[0]),
    .src_b_i  (rf_rdata[1]),
    .cc_i     (cc_q),
    .res_o    (res)
  );

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    cc_d      = cc_q;
    retired_d = retired_q;
    ir_op_d   = ir_op_q;
    ir_dr_d   = ir_dr_q;
    mem_rd    = 1'b0;
    mem_addr  = pc_q;
    rf_we     = 1'b0;
    rf_waddr  = RAW'(res.rf_addr);
    rf_wdata  = res.rf_data;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd  = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        ir_op_d = mem_rdata[15:12];
        ir_dr_d = mem_rdata[11:9];
        pc_d    = res.next_pc;
        rf_we   = res.rf_we;
        if (res.cc_we) cc_d = flags_of(res.rf_data);
        if (res.mem_rd) begin
          mem_rd   = 1'b1;
          mem_addr = res.mem_addr;
          state_d  = ST_MEM;
        end else begin
          retired_d = retired_q + CNT_W'(1);
          state_d   = (res.next_pc == '0) ? ST_HALT : ST_FETCH;
        end
      end
      ST_MEM: begin
        retired_d = retired_q + CNT_W'(1);
        if (ir_op_q == OP_TRAP) begin
          pc_d    = mem_rdata;
          state_d = (mem_rdata == '0) ? ST_HALT : ST_FETCH;
        end else begin
          rf_we    = 1'b1;
          rf_waddr = RAW'(ir_dr_q);
          rf_wdata = mem_rdata;
          cc_d     = flags_of(mem_rdata);
          state_d  = (pc_q == '0) ? ST_HALT : ST_FETCH;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FETCH;
      pc_q      <= RESET_PC;
      cc_q      <= 3'b010;
      retired_q <= '0;
      ir_op_q   <= '0;
      ir_dr_q   <= '0;
    end else begin
      state_q   <= state_d;
      pc_q      <= pc_d;
      cc_q      <= cc_d;
      retired_q <= retired_d;
      ir_op_q   <= ir_op_d;
      ir_dr_q   <= ir_dr_d;
    end
  end

  assign dbg_data_o = rf_rdata[2];
  assign pc_o       = pc_q;
  assign cc_o       = cc_q;
  assign retired_o  = retired_q;
  assign halted_o   = (state_q == ST_HALT);

  assert_cc_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cc_q) == 1);

  assert_br_nomask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && mem_rdata[15:12] == OP_BR && mem_rdata[11:9] == 3'b000)
    |=> (pc_q == $past(pc_q) + XLEN'(2)));

  assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_q) && $stable(retired_q)));

  assert_halt_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> (pc_q == '0));

  assert_retire_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retired_q != $past(retired_q)) |-> (retired_q == $past(retired_q) + CNT_W'(1)));

  assert_retire_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retired_q != $past(retired_q)) |=> $stable(retired_q));

  assert_fetch_exec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |=> (state_q == ST_EXEC));
endmodule

// File: tb/m16_core_tb.sv
`timescale 1ns/1ps
module m16_core_tb;
  localparam int MEM_AW = 12;
  localparam int CNT_W  = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_we_i = 1'b0;
  logic [MEM_AW-1:0] load_addr_i = '0;
  logic [15:0]       load_data_i = '0;
  logic [2:0]        dbg_sel_i = '0;
  logic [15:0]       dbg_data_o;
  logic [15:0]       pc_o;
  logic [2:0]        cc_o;
  logic [CNT_W-1:0]  retired_o;
  logic              halted_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  m16_core #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_we_i(load_we_i), .load_addr_i(load_addr_i),
    .load_data_i(load_data_i), .dbg_sel_i(dbg_sel_i), .dbg_data_o(dbg_data_o),
    .pc_o(pc_o), .cc_o(cc_o), .retired_o(retired_o), .halted_o(halted_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [15:0] i0, i1, i2;
    logic [2:0]  rsel;
    logic [15:0] exp_val;
    logic [2:0]  exp_cc;
    logic [7:0]  exp_ret;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h1227, 16'h1478, 16'hD000, 3'd2, 16'hFFFF, 3'b100, 8'd4}, // R2 negative imm
    '{16'h122F, 16'h146F, 16'h1642, 3'd3, 16'h002D, 3'b001, 8'd4}, // R2 register mode
    '{16'h1225, 16'h127B, 16'hD000, 3'd1, 16'h0000, 3'b010, 8'd4}, // R2 zero result
    '{16'h1830, 16'hD000, 16'hD000, 3'd4, 16'hFFF0, 3'b100, 8'd4}, // R2 sext -16
    '{16'hEA05, 16'hD000, 16'hD000, 3'd5, 16'h300C, 3'b001, 8'd4}, // R3 fwd offset
    '{16'hD000, 16'hEDFF, 16'hD000, 3'd6, 16'h3002, 3'b001, 8'd4}, // R3 neg offset, R8 no-op
    '{16'hE207, 16'h6441, 16'hD000, 3'd2, 16'h1234, 3'b001, 8'd4}, // R4 pos offset
    '{16'hE208, 16'h667F, 16'hD000, 3'd3, 16'h8001, 3'b100, 8'd4}, // R4 neg offset
    '{16'hE207, 16'h1261, 16'h6840, 3'd4, 16'h8001, 3'b100, 8'd4}, // R4 odd base
    '{16'h1221, 16'h0201, 16'h1425, 3'd2, 16'h0000, 3'b001, 8'd3}, // R5 taken
    '{16'h1221, 16'h0C01, 16'h1425, 3'd2, 16'h0005, 3'b001, 8'd4}, // R5 not taken
    '{16'h1220, 16'h0001, 16'h1425, 3'd2, 16'h0005, 3'b001, 8'd4}, // R5 mask 000
    '{16'h123F, 16'hD000, 16'hD000, 3'd7, 16'h3008, 3'b100, 8'd4}  // R6 link, flags kept
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    load_we_i = 1'b1; load_addr_i = a[MEM_AW-1:0]; load_data_i = d;
    @(posedge clk);
    #1 load_we_i = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    mem_write(16'h004A, 16'h0000);
    mem_write(16'h3010, 16'h8001);
    mem_write(16'h3012, 16'h1234);
  endtask

  task automatic release_and_wait(output int cyc);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc = 0;
    while (!halted_o && cyc < 2000) begin
      @(posedge clk); @(negedge clk);
      cyc++;
    end
  endtask

  task automatic read_reg(input logic [2:0] r, output logic [15:0] v);
    @(negedge clk);
    dbg_sel_i = r;
    #1 v = dbg_data_o;
  endtask

  initial begin
    logic [15:0] v;
    int cyc;

    // directed: reset state and count-down program
    enter_reset();
    mem_write(16'h3000, 16'hE005); mem_write(16'h3002, 16'h6200);
    mem_write(16'h3004, 16'h127F); mem_write(16'h3006, 16'h0401);
    mem_write(16'h3008, 16'h0FFD); mem_write(16'h300A, 16'hF025);
    mem_write(16'h300C, 16'h000A);
    @(negedge clk);
    check(pc_o == 16'h3000, "R1 reset pc", pc_o, 16'h3000);
    check(retired_o == 0, "R1 reset count", retired_o, 0);
    check(halted_o == 1'b0, "R1 reset halted", halted_o, 0);
    check(cc_o == 3'b010, "R1 reset cc", cc_o, 3'b010);
    for (int r = 0; r < 8; r++) begin
      read_reg(3'(r), v);
      check(v == 16'h0000, "R1 reset reg", v, 0);
    end
    release_and_wait(cyc);
    check(halted_o && pc_o == 16'h0000, "R10 halted at pc 0", pc_o, 0);
    check(retired_o == 32, "R10 retired", retired_o, 32);
    check(cc_o == 3'b010, "R10 cc", cc_o, 3'b010);
    read_reg(3'd0, v); check(v == 16'h300C, "R10 r0", v, 16'h300C);
    read_reg(3'd1, v); check(v == 16'h0000, "R10 r1", v, 0);
    read_reg(3'd7, v); check(v == 16'h300C, "R10 r7", v, 16'h300C);
    repeat (20) @(negedge clk);
    check(retired_o == 32, "R7 count frozen after halt", retired_o, 32);
    check(halted_o && pc_o == 16'h0000, "R7 pc held after halt", pc_o, 0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      enter_reset();
      mem_write(16'h3000, VECS[k].i0);
      mem_write(16'h3002, VECS[k].i1);
      mem_write(16'h3004, VECS[k].i2);
      mem_write(16'h3006, 16'hF025);
      release_and_wait(cyc);
      check(halted_o && pc_o == 16'h0000, $sformatf("R7 vec %0d halt", k), pc_o, 0);
      check(retired_o == 32'(VECS[k].exp_ret), $sformatf("R8 vec %0d count", k), retired_o, VECS[k].exp_ret);
      read_reg(VECS[k].rsel, v);
      check(v == VECS[k].exp_val, $sformatf("vec %0d reg", k), v, VECS[k].exp_val);
      check(cc_o == VECS[k].exp_cc, $sformatf("vec %0d cc", k), cc_o, VECS[k].exp_cc);
    end

    // R9 timing: three no-ops (2 cycles each) then TRAP (3 cycles)
    enter_reset();
    mem_write(16'h3000, 16'hD000); mem_write(16'h3002, 16'hD000);
    mem_write(16'h3004, 16'hD000); mem_write(16'h3006, 16'hF025);
    release_and_wait(cyc);
    check(cyc == 9, "R9 cycles to halt", cyc, 9);

    // R6 nonzero trap vector: TRAP x30 -> word 0x0060 = 0x3040
    enter_reset();
    mem_write(16'h3000, 16'hF030);
    mem_write(16'h0060, 16'h3040);
    mem_write(16'h3040, 16'h1623);
    mem_write(16'h3042, 16'hF025);
    release_and_wait(cyc);
    check(retired_o == 3, "R6 trap path count", retired_o, 3);
    read_reg(3'd3, v); check(v == 16'h0003, "R6 trap target ran", v, 3);
    read_reg(3'd7, v); check(v == 16'h3044, "R6 link of last trap", v, 16'h3044);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule